// File: doc/BRIEF.md
# Process Timeout Tick and Scan Unit

This block keeps a per-system tick counter that advances at a fixed pace taken from a free-running interval timer, and after every tick it walks a table of per-process timeout words. Each timeout word holds an absolute tick number at which the process should stop waiting, with zero meaning that the process is not timed. When a stored deadline matches the current tick, the block clears the timeout word and the waiting bit of the process flag word, and it issues a wakeup request carrying the table index. The source queue of such a wakeup is unknown, so the queue logic that consumes the request must locate it. When the walk is over, a single pulse reports whether any process was woken.

The tick counter never holds zero. It starts at one after reset and steps from its maximum value straight to one. A tick is taken only while interrupts are enabled, and at most one tick is taken per qualifying cycle, so intervals missed while interrupts were off are not made up. A tick that becomes due while a walk is still running waits until the walk has ended. The block also turns a wait interval into a stored deadline. A zero interval gives zero. Any other interval gives the tick counter plus the interval, with a result that wraps to zero replaced by one.

The table sits outside the block behind a simple request/ready port: one read or one write per cycle at most. Read data is returned the cycle after a read is accepted, and any request waits while ready is low.

Top module: `proc_timeout_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, tick_count is 1, deadline is 0, and wake_valid, scan_done, scan_any, tbl_rd_en and tbl_wr_en are all 0.
- R2: Each tick increments tick_count by one modulo 2^TICK_W. A result of 0 is replaced by 1, so the maximum value is followed by 1 and tick_count never reads 0.
- R3: A tick is taken at the clock edge of a cycle in which intr_en is 1, no scan is running, and (timer_now minus the saved time) modulo 2^TIMER_W is at least tick_period. That edge also copies timer_now into the saved time. However many periods have elapsed, one such cycle yields exactly one tick.
- R4: No tick is taken while intr_en is 0.
- R5: Each tick starts a scan of indices tbl_base, tbl_base+1, ... for tbl_count entries, with indices taken modulo 2^IDX_W. If tbl_count is 0, the tick is taken at one edge, scan_done rises at the next edge, and scan_any is then 0.
- R6: An entry in the scanned range whose timeout word is nonzero and equal to tick_count is written back with timeout 0 and with flag bit 14 (the waiting bit) cleared, all other flag bits unchanged. A one-cycle wake_valid pulse then carries its index on wake_idx. Entries outside the range, and entries whose timeout is 0 or different, are left unchanged and produce no wake.
- R7: A scan ends with a one-cycle scan_done pulse. scan_any, valid from that pulse until the next one, is 1 exactly when the scan woke at least one entry.
- R8: One cycle after wait_interval is presented, deadline shows 0 if the interval is 0. Otherwise it shows (tick_count + wait_interval) modulo 2^TICK_W, with a result of 0 replaced by 1.
- R9: A table request is held with its address unchanged while tbl_ready is 0. A tick that becomes due while a scan is running leaves tick_count unchanged until the scan has ended, and is taken afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intr_en | input | 1 | Interrupts enabled level; ticks only while high |
| timer_now | input | TIMER_W | Free-running interval timer value |
| tick_period | input | TIMER_W | Timer advance needed for one tick |
| tbl_base | input | IDX_W | First table index to scan |
| tbl_count | input | IDX_W+1 | Number of table entries to scan |
| wait_interval | input | TICK_W | Wait length in ticks for the deadline calculation |
| deadline | output | TICK_W | Registered deadline for wait_interval, 0 = never |
| tick_count | output | TICK_W | Current tick counter, never 0 |
| tbl_rd_en | output | 1 | Table read request |
| tbl_wr_en | output | 1 | Table write request |
| tbl_addr | output | IDX_W | Table index of the current request |
| tbl_wr_tmo | output | TICK_W | Timeout word to write |
| tbl_wr_flg | output | FLAG_W | Flag word to write |
| tbl_ready | input | 1 | Table accepts the current request |
| tbl_rd_tmo | input | TICK_W | Timeout word, valid the cycle after a read is accepted |
| tbl_rd_flg | input | FLAG_W | Flag word, valid the cycle after a read is accepted |
| wake_valid | output | 1 | One-cycle wakeup request for an expired entry |
| wake_idx | output | IDX_W | Table index of the woken entry |
| scan_done | output | 1 | One-cycle pulse at the end of a scan |
| scan_any | output | 1 | Last scan woke at least one entry |

## Verification
The tick counter is swept through more than one full wrap of a narrow counter. This separates a correct skip over zero from a plain wrap or a double step, and at every step the deadline is tried with a zero interval, an interval whose sum wraps to exactly zero, and a spread of ordinary values. Timer steps just below, at and several times above the period, and a stretch with interrupts disabled, separate the threshold test from an off-by-one and show that missed periods are not made up. Table patterns mix matching, zero and off-by-one deadlines with varied flag bits, over ranges that are interior, that wrap past the last index, that cover the whole table and that hold a single entry. This exposes range bounds, a wrong flag mask and stray writes. The same patterns are repeated under random ready stalls, and a tick is made due in the middle of a stalled scan to show that it is held.

// File: rtl/ptu_pkg.sv
package ptu_pkg;

  typedef enum logic [2:0] {
    SC_IDLE  = 3'd0,
    SC_READ  = 3'd1,
    SC_CHECK = 3'd2,
    SC_WRITE = 3'd3,
    SC_DONE  = 3'd4
  } scan_state_t;

endpackage

// File: rtl/ptu_tick_gen.sv
module ptu_tick_gen #(
  parameter int TIMER_W = 16,
  parameter int TICK_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               intr_en,
  input  logic               scan_busy,
  input  logic [TIMER_W-1:0] timer_now,
  input  logic [TIMER_W-1:0] tick_period,
  output logic               tick_fire,
  output logic [TICK_W-1:0]  tick_val
);

  logic [TIMER_W-1:0] saved_q;
  logic [TIMER_W-1:0] elapsed;
  logic [TICK_W-1:0]  tick_q;
  logic [TICK_W-1:0]  tick_inc;
  logic [TICK_W-1:0]  tick_nxt;

  assign elapsed   = timer_now - saved_q;
  assign tick_fire = intr_en && !scan_busy && (elapsed >= tick_period);
  assign tick_inc  = tick_q + TICK_W'(1);
  assign tick_nxt  = (tick_inc == '0) ? TICK_W'(1) : tick_inc;
  assign tick_val  = tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      saved_q <= '0;
      tick_q  <= TICK_W'(1);
    end else if (tick_fire) begin
      saved_q <= timer_now;
      tick_q  <= tick_nxt;
    end
  end

  // R2
  tick_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    tick_q != '0);

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (tick_q != $past(tick_q))) |->
      ((tick_q == TICK_W'($past(tick_q) + TICK_W'(1))) ||
       ((tick_q == TICK_W'(1)) && ($past(tick_q) == '1))));

  // R4
  no_tick_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !intr_en |=> $stable(tick_q));

  // R9
  tick_held_chk: assert property (@(posedge clk) disable iff (rst)
    scan_busy |=> $stable(tick_q));

endmodule

// File: rtl/ptu_deadline.sv
module ptu_deadline #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TICK_W-1:0] tick_val,
  input  logic [TICK_W-1:0] interval,
  output logic [TICK_W-1:0] deadline
);

  logic [TICK_W-1:0] sum;
  logic [TICK_W-1:0] dl_nxt;
  logic [TICK_W-1:0] dl_q;

  assign sum    = tick_val + interval;
  assign dl_nxt = (interval == '0) ? '0 :
                  (sum == '0)      ? TICK_W'(1) : sum;
  assign deadline = dl_q;

  always_ff @(posedge clk) begin
    if (rst) dl_q <= '0;
    else     dl_q <= dl_nxt;
  end

  // R8
  never_zero_interval_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(interval) == '0) |-> (dl_q == '0));

  // R8
  timed_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(interval) != '0)) |-> (dl_q != '0));

endmodule

// File: rtl/ptu_scan_engine.sv
module ptu_scan_engine
  import ptu_pkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int TICK_W   = 16,
  parameter int FLAG_W   = 16,
  parameter int WAIT_BIT = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TICK_W-1:0] tick_val,
  input  logic [IDX_W-1:0]  base,
  input  logic [IDX_W:0]    count,
  input  logic              tbl_ready,
  input  logic [TICK_W-1:0] rd_tmo,
  input  logic [FLAG_W-1:0] rd_flg,
  output logic              rd_en,
  output logic              wr_en,
  output logic [IDX_W-1:0]  addr,
  output logic [TICK_W-1:0] wr_tmo,
  output logic [FLAG_W-1:0] wr_flg,
  output logic              wake_valid,
  output logic [IDX_W-1:0]  wake_idx,
  output logic              done,
  output logic              any,
  output logic              busy
);

  localparam int CNT_W = IDX_W + 1;
  localparam logic [FLAG_W-1:0] WAIT_MASK = FLAG_W'(1) << WAIT_BIT;

  scan_state_t       state_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  addr_q;
  logic [FLAG_W-1:0] wr_flg_q;
  logic              any_q;
  logic              any_out_q;
  logic              done_q;
  logic              wake_q;
  logic [IDX_W-1:0]  wake_idx_q;
  logic              hit;
  logic              last;
  scan_state_t       adv_state;

  assign hit       = (rd_tmo != '0) && (rd_tmo == tick_val);
  assign last      = (CNT_W'(idx_q + CNT_W'(1)) == cnt_q);
  assign adv_state = last ? SC_DONE : SC_READ;

  assign rd_en      = (state_q == SC_READ);
  assign wr_en      = (state_q == SC_WRITE);
  assign addr       = addr_q;
  assign wr_tmo     = '0;
  assign wr_flg     = wr_flg_q;
  assign wake_valid = wake_q;
  assign wake_idx   = wake_idx_q;
  assign done       = done_q;
  assign any        = any_out_q;
  assign busy       = (state_q != SC_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SC_IDLE;
      idx_q      <= '0;
      cnt_q      <= '0;
      addr_q     <= '0;
      wr_flg_q   <= '0;
      any_q      <= 1'b0;
      any_out_q  <= 1'b0;
      done_q     <= 1'b0;
      wake_q     <= 1'b0;
      wake_idx_q <= '0;
    end else begin
      done_q <= 1'b0;
      wake_q <= 1'b0;
      case (state_q)
        SC_IDLE: begin
          if (start) begin
            idx_q   <= '0;
            cnt_q   <= count;
            addr_q  <= base;
            any_q   <= 1'b0;
            state_q <= (count == '0) ? SC_DONE : SC_READ;
          end
        end
        SC_READ: begin
          if (tbl_ready) state_q <= SC_CHECK;
        end
        SC_CHECK: begin
          if (hit) begin
            wr_flg_q <= rd_flg & ~WAIT_MASK;
            state_q  <= SC_WRITE;
          end else begin
            idx_q   <= idx_q + CNT_W'(1);
            addr_q  <= addr_q + IDX_W'(1);
            state_q <= adv_state;
          end
        end
        SC_WRITE: begin
          if (tbl_ready) begin
            wake_q     <= 1'b1;
            wake_idx_q <= addr_q;
            any_q      <= 1'b1;
            idx_q      <= idx_q + CNT_W'(1);
            addr_q     <= addr_q + IDX_W'(1);
            state_q    <= adv_state;
          end
        end
        SC_DONE: begin
          done_q    <= 1'b1;
          any_out_q <= any_q;
          state_q   <= SC_IDLE;
        end
        default: state_q <= SC_IDLE;
      endcase
    end
  end

  // R9
  one_access_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  // R9
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !tbl_ready) |=> (rd_en && $stable(addr)));

  // R9
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !tbl_ready) |=> (wr_en && $stable(addr) && $stable(wr_flg)));

  // R6
  wake_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    wake_valid |-> $past(wr_en && tbl_ready));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/proc_timeout_unit.sv
module proc_timeout_unit #(
  parameter int TIMER_W  = 16,
  parameter int TICK_W   = 16,
  parameter int IDX_W    = 10,
  parameter int FLAG_W   = 16,
  parameter int WAIT_BIT = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               intr_en,
  input  logic [TIMER_W-1:0] timer_now,
  input  logic [TIMER_W-1:0] tick_period,
  input  logic [IDX_W-1:0]   tbl_base,
  input  logic [IDX_W:0]     tbl_count,
  input  logic [TICK_W-1:0]  wait_interval,
  output logic [TICK_W-1:0]  deadline,
  output logic [TICK_W-1:0]  tick_count,
  output logic               tbl_rd_en,
  output logic               tbl_wr_en,
  output logic [IDX_W-1:0]   tbl_addr,
  output logic [TICK_W-1:0]  tbl_wr_tmo,
  output logic [FLAG_W-1:0]  tbl_wr_flg,
  input  logic               tbl_ready,
  input  logic [TICK_W-1:0]  tbl_rd_tmo,
  input  logic [FLAG_W-1:0]  tbl_rd_flg,
  output logic               wake_valid,
  output logic [IDX_W-1:0]   wake_idx,
  output logic               scan_done,
  output logic               scan_any
);

  logic              tick_fire;
  logic              scan_busy;
  logic [TICK_W-1:0] tick_val;

  ptu_tick_gen #(
    .TIMER_W (TIMER_W),
    .TICK_W  (TICK_W)
  ) u_tick (
    .clk         (clk),
    .rst         (rst),
    .intr_en     (intr_en),
    .scan_busy   (scan_busy),
    .timer_now   (timer_now),
    .tick_period (tick_period),
    .tick_fire   (tick_fire),
    .tick_val    (tick_val)
  );

  ptu_deadline #(
    .TICK_W (TICK_W)
  ) u_deadline (
    .clk      (clk),
    .rst      (rst),
    .tick_val (tick_val),
    .interval (wait_interval),
    .deadline (deadline)
  );

  ptu_scan_engine #(
    .IDX_W    (IDX_W),
    .TICK_W   (TICK_W),
    .FLAG_W   (FLAG_W),
    .WAIT_BIT (WAIT_BIT)
  ) u_scan (
    .clk        (clk),
    .rst        (rst),
    .start      (tick_fire),
    .tick_val   (tick_val),
    .base       (tbl_base),
    .count      (tbl_count),
    .tbl_ready  (tbl_ready),
    .rd_tmo     (tbl_rd_tmo),
    .rd_flg     (tbl_rd_flg),
    .rd_en      (tbl_rd_en),
    .wr_en      (tbl_wr_en),
    .addr       (tbl_addr),
    .wr_tmo     (tbl_wr_tmo),
    .wr_flg     (tbl_wr_flg),
    .wake_valid (wake_valid),
    .wake_idx   (wake_idx),
    .done       (scan_done),
    .any        (scan_any),
    .busy       (scan_busy)
  );

  assign tick_count = tick_val;

  // R5
  wake_in_scan_chk: assert property (@(posedge clk) disable iff (rst)
    wake_valid |-> (scan_busy || scan_done || $past(scan_busy)));

  // R1
  quiet_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!wake_valid && !scan_done && !tbl_rd_en && !tbl_wr_en));

endmodule

// File: tb/proc_timeout_unit_tb.sv
module proc_timeout_unit_tb;

  localparam int TIMER_W = 16;
  localparam int TICK_W  = 8;
  localparam int IDX_W   = 4;
  localparam int FLAG_W  = 16;
  localparam int NENT    = 1 << IDX_W;
  localparam logic [15:0] PERIOD = 16'd10;

  logic               clk = 1'b0;
  logic               rst;
  logic               intr_en;
  logic [TIMER_W-1:0] timer_now;
  logic [TIMER_W-1:0] tick_period;
  logic [IDX_W-1:0]   tbl_base;
  logic [IDX_W:0]     tbl_count;
  logic [TICK_W-1:0]  wait_interval;
  logic [TICK_W-1:0]  deadline;
  logic [TICK_W-1:0]  tick_count;
  logic               tbl_rd_en, tbl_wr_en;
  logic [IDX_W-1:0]   tbl_addr;
  logic [TICK_W-1:0]  tbl_wr_tmo;
  logic [FLAG_W-1:0]  tbl_wr_flg;
  logic               tbl_ready;
  logic [TICK_W-1:0]  tbl_rd_tmo;
  logic [FLAG_W-1:0]  tbl_rd_flg;
  logic               wake_valid;
  logic [IDX_W-1:0]   wake_idx;
  logic               scan_done, scan_any;

  always #2 clk = ~clk;

  proc_timeout_unit #(
    .TIMER_W(TIMER_W), .TICK_W(TICK_W), .IDX_W(IDX_W), .FLAG_W(FLAG_W), .WAIT_BIT(14)
  ) u_dut (
    .clk(clk), .rst(rst), .intr_en(intr_en), .timer_now(timer_now),
    .tick_period(tick_period), .tbl_base(tbl_base), .tbl_count(tbl_count),
    .wait_interval(wait_interval), .deadline(deadline), .tick_count(tick_count),
    .tbl_rd_en(tbl_rd_en), .tbl_wr_en(tbl_wr_en), .tbl_addr(tbl_addr),
    .tbl_wr_tmo(tbl_wr_tmo), .tbl_wr_flg(tbl_wr_flg), .tbl_ready(tbl_ready),
    .tbl_rd_tmo(tbl_rd_tmo), .tbl_rd_flg(tbl_rd_flg), .wake_valid(wake_valid),
    .wake_idx(wake_idx), .scan_done(scan_done), .scan_any(scan_any)
  );

  // table model
  logic [TICK_W-1:0] m_tmo [NENT];
  logic [FLAG_W-1:0] m_flg [NENT];
  logic              ld_en;
  logic [IDX_W-1:0]  ld_idx;
  logic [TICK_W-1:0] ld_tmo;
  logic [FLAG_W-1:0] ld_flg;

  always @(posedge clk) begin
    if (ld_en) begin
      m_tmo[ld_idx] <= ld_tmo;
      m_flg[ld_idx] <= ld_flg;
    end
    if (tbl_rd_en && tbl_ready) begin
      tbl_rd_tmo <= m_tmo[tbl_addr];
      tbl_rd_flg <= m_flg[tbl_addr];
    end
    if (tbl_wr_en && tbl_ready) begin
      m_tmo[tbl_addr] <= tbl_wr_tmo;
      m_flg[tbl_addr] <= tbl_wr_flg;
    end
  end

  logic        stall_mode;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tbl_ready = stall_mode ? lfsr[0] : 1'b1;
  end

  // reference state
  logic [TICK_W-1:0] r_tmo [NENT];
  logic [FLAG_W-1:0] r_flg [NENT];
  logic [TICK_W-1:0] exp_tick;
  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  function automatic logic [TICK_W-1:0] nxt(input logic [TICK_W-1:0] t);
    logic [TICK_W-1:0] n;
    n = t + TICK_W'(1);
    return (n == '0) ? TICK_W'(1) : n;
  endfunction

  function automatic logic [TICK_W-1:0] dl(input logic [TICK_W-1:0] t,
                                           input logic [TICK_W-1:0] w);
    logic [TICK_W-1:0] s;
    s = t + w;
    if (w == '0) return '0;
    return (s == '0) ? TICK_W'(1) : s;
  endfunction

  task automatic preload(input int seed);
    logic [TICK_W-1:0] nt;
    nt = nxt(exp_tick);
    for (int i = 0; i < NENT; i++) begin
      @(negedge clk);
      ld_en  = 1'b1;
      ld_idx = IDX_W'(i);
      case ((i + seed) % 3)
        0:       ld_tmo = nt;
        1:       ld_tmo = '0;
        default: ld_tmo = nt + TICK_W'(1);
      endcase
      ld_flg = 16'(i * 16'h1357 + seed * 16'h0101);
      r_tmo[i] = ld_tmo;
      r_flg[i] = ld_flg;
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic ref_scan(input int base, input int cnt, input logic [TICK_W-1:0] t,
                          output logic [NENT-1:0] mask);
    mask = '0;
    for (int k = 0; k < cnt; k++) begin
      int a;
      a = (base + k) % NENT;
      if (r_tmo[a] != '0 && r_tmo[a] == t) begin
        mask[a] = 1'b1;
        r_tmo[a] = '0;
        r_flg[a] = r_flg[a] & ~16'h4000;
      end
    end
  endtask

  task automatic wait_scan(output logic [NENT-1:0] mask, output bit any, output bit held);
    bit seen;
    mask = '0; any = 0; held = 1; seen = 0;
    for (int c = 0; c < 600 && !seen; c++) begin
      @(negedge clk);
      if (wake_valid) mask[wake_idx] = 1'b1;
      if (tick_count != exp_tick) held = 0;
      if (scan_done) begin
        seen = 1;
        any = scan_any;
      end
    end
    chk(seen, "R7 scan_done seen", int'(seen), 1);
  endtask

  task automatic compare_scan(input logic [NENT-1:0] got, input logic [NENT-1:0] expm,
                              input bit any);
    chk(got == expm, "R5/R6 woken set", int'(got), int'(expm));
    chk(any == (expm != '0), "R7 scan_any", int'(any), int'(expm != '0));
    for (int a = 0; a < NENT; a++) begin
      chk(m_tmo[a] == r_tmo[a], $sformatf("R6 timeout word %0d", a),
          int'(m_tmo[a]), int'(r_tmo[a]));
      chk(m_flg[a] == r_flg[a], $sformatf("R6 flag word %0d", a),
          int'(m_flg[a]), int'(r_flg[a]));
    end
  endtask

  task automatic run_scan(input int base, input int cnt, input bit stall, input bit hold,
                          input int seed);
    logic [NENT-1:0] got, expm;
    bit any, held;
    preload(seed);
    stall_mode = stall;
    tbl_base  = IDX_W'(base);
    tbl_count = (IDX_W+1)'(cnt);
    timer_now = timer_now + PERIOD;
    @(negedge clk);
    chk(tick_count == nxt(exp_tick), "R3 tick for scan", int'(tick_count), int'(nxt(exp_tick)));
    exp_tick = nxt(exp_tick);
    if (hold) timer_now = timer_now + PERIOD;
    ref_scan(base, cnt, exp_tick, expm);
    wait_scan(got, any, held);
    chk(held, "R9 tick held during scan", int'(held), 1);
    compare_scan(got, expm, any);
    if (hold) begin
      @(negedge clk);
      chk(tick_count == nxt(exp_tick), "R9 held tick taken after scan",
          int'(tick_count), int'(nxt(exp_tick)));
      exp_tick = nxt(exp_tick);
      ref_scan(base, cnt, exp_tick, expm);
      wait_scan(got, any, held);
      compare_scan(got, expm, any);
    end
    stall_mode = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; intr_en = 1'b1; timer_now = '0; tick_period = PERIOD;
    tbl_base = '0; tbl_count = '0; wait_interval = '0; stall_mode = 1'b0;
    ld_en = 1'b0; ld_idx = '0; ld_tmo = '0; ld_flg = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(tick_count == 8'd1, "R1 tick_count in reset", int'(tick_count), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(tick_count == 8'd1, "R1 tick_count after reset", int'(tick_count), 1);
    chk(deadline == '0, "R1 deadline", int'(deadline), 0);
    chk(!wake_valid && !scan_done && !scan_any && !tbl_rd_en && !tbl_wr_en,
        "R1 outputs idle", int'({wake_valid, scan_done, scan_any, tbl_rd_en, tbl_wr_en}), 0);
    exp_tick = 8'd1;

    // R2 / R8 / R5 wrap sweep with an empty scan range
    for (int k = 0; k < 300; k++) begin
      logic [TICK_W-1:0] w;
      timer_now = timer_now + PERIOD;
      @(negedge clk);
      chk(tick_count == nxt(exp_tick), "R2 tick step", int'(tick_count), int'(nxt(exp_tick)));
      exp_tick = nxt(exp_tick);
      case (k % 3)
        0:       w = '0;
        1:       w = TICK_W'(256 - int'(exp_tick));
        default: w = TICK_W'(k * 37);
      endcase
      wait_interval = w;
      @(negedge clk);
      chk(deadline == dl(exp_tick, w), "R8 deadline", int'(deadline), int'(dl(exp_tick, w)));
      chk(scan_done && !scan_any, "R5 empty range done", int'({scan_done, scan_any}), 2);
    end

    // R3 threshold and single tick for many periods
    @(negedge clk);
    timer_now = timer_now + PERIOD - 16'd1;
    repeat (3) @(negedge clk);
    chk(tick_count == exp_tick, "R3 below period", int'(tick_count), int'(exp_tick));
    timer_now = timer_now + 16'd1;
    @(negedge clk);
    chk(tick_count == nxt(exp_tick), "R3 at period", int'(tick_count), int'(nxt(exp_tick)));
    exp_tick = nxt(exp_tick);
    repeat (2) @(negedge clk);
    timer_now = timer_now + 16'd35;
    repeat (6) @(negedge clk);
    chk(tick_count == nxt(exp_tick), "R3 one tick for many periods",
        int'(tick_count), int'(nxt(exp_tick)));
    exp_tick = nxt(exp_tick);
    timer_now = timer_now + PERIOD - 16'd1;
    repeat (3) @(negedge clk);
    chk(tick_count == exp_tick, "R3 saved time updated", int'(tick_count), int'(exp_tick));

    // R4 interrupts disabled
    intr_en = 1'b0;
    timer_now = timer_now + 16'd50;
    repeat (6) @(negedge clk);
    chk(tick_count == exp_tick, "R4 no tick while disabled", int'(tick_count), int'(exp_tick));
    intr_en = 1'b1;
    @(negedge clk);
    chk(tick_count == nxt(exp_tick), "R4 tick after enable", int'(tick_count), int'(nxt(exp_tick)));
    exp_tick = nxt(exp_tick);
    repeat (5) @(negedge clk);
    chk(tick_count == exp_tick, "R4 missed ticks not made up", int'(tick_count), int'(exp_tick));

    // R5 R6 R7 R9 table scans
    run_scan(5, 8, 1'b0, 1'b0, 0);
    run_scan(12, 8, 1'b1, 1'b0, 1);
    run_scan(0, 16, 1'b1, 1'b0, 2);
    run_scan(3, 1, 1'b0, 1'b0, 0);
    run_scan(7, 1, 1'b1, 1'b0, 1);
    run_scan(2, 10, 1'b1, 1'b1, 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule